// File: doc/BRIEF.md
# Guarded Nonvolatile Byte Store Controller

This block sits on a CPU's 8-bit I/O bus and fronts a 512-byte byte-wide nonvolatile data store, modelled here as an inferred RAM. Software sees four byte registers: the low and high halves of a 9-bit address, a data byte, and a control byte. Setting the read bit fetches the addressed byte into the data register. A store is guarded by a two-step unlock: software arms an unlock bit, and the write bit must be set while that arm is live. The arm lapses by itself four clocks after it is set.

An accepted store runs for a fixed number of pulses of a separate slow timing tick. The tick is a one-cycle enable in the CPU clock domain and counts real-time programming duration regardless of the CPU clock rate. The write bit stays high for the whole store and serves as the busy flag software polls. While a store is in progress, read requests and address updates are dropped. The block also asks the CPU to stall after each accepted access, and raises a level ready interrupt.

Top module: `nvm_guard_ctrl`

## Requirements
- R1: Register select codes on `io_sel` are 0 for the address low byte, 1 for the address high byte, 2 for the data byte and 3 for the control byte. Only bit 0 of the address high byte is stored; its other bits read back as zero and writes to them are ignored.
- R2: The control byte reads back as ready-interrupt enable at bit 3, unlock arm at bit 2, write/busy at bit 1 and read at bit 0. Bits 7..4 always read as zero.
- R3: Writing control with bit 2 set arms the unlock. The arm reads as 1 for four cycles and then clears by itself. A write strobe (control bit 1) is accepted on any of the four clock edges after the arming edge, and is refused on the fifth.
- R4: A write strobe while the unlock is not armed has no effect. This includes a control write that carries the arm bit and the write bit together: that write only arms.
- R5: An accepted store writes the data byte to the addressed byte. It keeps control bit 1 high until WRITE_TICKS timing ticks have arrived after the start, then clears it.
- R6: Setting control bit 0 while idle loads the data register from the addressed byte on the next clock edge. The read bit reads 1 for one cycle and then clears by itself.
- R7: `cpu_stall` is high for four cycles after an accepted read and for two cycles after an accepted store start.
- R8: While a store is busy, writes to either address byte are ignored, and read requests neither change the data register nor stall.
- R9: A store cannot start while `flash_busy` is high.
- R10: `irq` is high, one cycle delayed, exactly while the ready-interrupt enable is set, no store is busy and `gie` is high.
- R11: After reset all registers read zero and `cpu_stall` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| io_sel | input | 2 | Register select |
| io_we | input | 1 | Bus write strobe |
| io_wdata | input | 8 | Bus write data |
| io_rdata | output | 8 | Read-back of the selected register |
| tick | input | 1 | One-cycle timing pulse for store duration |
| flash_busy | input | 1 | Flash self-programming in progress |
| gie | input | 1 | Global interrupt enable |
| cpu_stall | output | 1 | Request to halt the CPU |
| irq | output | 1 | Level ready interrupt |

## Verification
The hardest situation to reach is the edge of the unlock window. A strobe on the fourth edge after arming must start a store, and the same strobe one edge later must not. The stimulus arms the unlock and then waits an exact count of falling edges before issuing the strobe, for both cases. The lockouts are only visible during the long busy period. To keep that period short, the bench shortens the tick count, and it issues address writes and read requests while the busy flag is still polled as high.

// File: rtl/nvm_guard_pkg.sv
package nvm_guard_pkg;
  typedef enum logic [1:0] {
    REG_ADDR_LO = 2'd0,
    REG_ADDR_HI = 2'd1,
    REG_DATA    = 2'd2,
    REG_CTRL    = 2'd3
  } nvm_reg_e;

  localparam int CB_RD  = 0;
  localparam int CB_WR  = 1;
  localparam int CB_ARM = 2;
  localparam int CB_IE  = 3;
endpackage

// File: rtl/nvm_unlock.sv
module nvm_unlock #(
  parameter int WINDOW = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic arm_req,
  input  logic consume,
  output logic armed
);
  localparam int CW = $clog2(WINDOW + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (consume)      cnt_q <= '0;
    else if (arm_req)      cnt_q <= CW'(WINDOW);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign armed = (cnt_q != '0);

  // R3: the arm only appears after a request
  p_arm_rise_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> $past(arm_req));
endmodule

// File: rtl/nvm_write_timer.sv
module nvm_write_timer #(
  parameter int TICKS = 8448
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic tick,
  output logic busy
);
  localparam int CW = $clog2(TICKS + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt_q <= '0;
    end else if (busy && tick) begin
      if (cnt_q == CW'(TICKS - 1)) busy <= 1'b0;
      else                         cnt_q <= cnt_q + 1'b1;
    end
  end

  // R5: a store only finishes on a timing tick
  p_done_on_tick_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(tick));
endmodule

// File: rtl/nvm_store.sv
module nvm_store #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/nvm_guard_ctrl.sv
module nvm_guard_ctrl
  import nvm_guard_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int DATA_W      = 8,
  parameter int WRITE_TICKS = 8448,
  parameter int ARM_WINDOW  = 4,
  parameter int RD_STALL    = 4,
  parameter int WR_STALL    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        io_sel,
  input  logic              io_we,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  input  logic              tick,
  input  logic              flash_busy,
  input  logic              gie,
  output logic              cpu_stall,
  output logic              irq
);
  localparam int HI_W      = ADDR_W - DATA_W;
  localparam int STALL_MAX = (RD_STALL > WR_STALL) ? RD_STALL : WR_STALL;
  localparam int SW        = $clog2(STALL_MAX + 1);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] ram_rdata;
  logic              ie_q, rd_pend_q, irq_q;
  logic [SW-1:0]     stall_q;
  logic              armed, busy;
  logic              ctrl_wr, start_wr, rd_go, arm_req;

  assign ctrl_wr  = io_we && (io_sel == REG_CTRL);
  assign start_wr = ctrl_wr && io_wdata[CB_WR] && armed && !busy && !flash_busy;
  assign rd_go    = ctrl_wr && io_wdata[CB_RD] && !busy && !start_wr;
  assign arm_req  = ctrl_wr && io_wdata[CB_ARM] && !start_wr;

  nvm_unlock #(.WINDOW(ARM_WINDOW)) u_unlock (
    .clk(clk), .rst(rst), .arm_req(arm_req), .consume(start_wr), .armed(armed)
  );

  nvm_write_timer #(.TICKS(WRITE_TICKS)) u_timer (
    .clk(clk), .rst(rst), .start(start_wr), .tick(tick), .busy(busy)
  );

  nvm_store #(.AW(ADDR_W), .DW(DATA_W)) u_store (
    .clk(clk), .en(rd_go | start_wr), .we(start_wr),
    .addr(addr_q), .wdata(data_q), .rdata(ram_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (io_we && !busy) begin
      if (io_sel == REG_ADDR_LO) addr_q[DATA_W-1:0]      <= io_wdata;
      if (io_sel == REG_ADDR_HI) addr_q[ADDR_W-1:DATA_W] <= io_wdata[HI_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                data_q <= '0;
    else if (rd_pend_q)                     data_q <= ram_rdata;
    else if (io_we && io_sel == REG_DATA)   data_q <= io_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q      <= 1'b0;
      rd_pend_q <= 1'b0;
      irq_q     <= 1'b0;
      stall_q   <= '0;
    end else begin
      if (ctrl_wr) ie_q <= io_wdata[CB_IE];
      rd_pend_q <= rd_go;
      irq_q     <= ie_q && !busy && gie;
      if (rd_go)               stall_q <= SW'(RD_STALL);
      else if (start_wr)       stall_q <= SW'(WR_STALL);
      else if (stall_q != '0)  stall_q <= stall_q - 1'b1;
    end
  end

  assign cpu_stall = (stall_q != '0);
  assign irq       = irq_q;

  always_comb begin
    case (io_sel)
      REG_ADDR_LO: io_rdata = addr_q[DATA_W-1:0];
      REG_ADDR_HI: io_rdata = {{(DATA_W-HI_W){1'b0}}, addr_q[ADDR_W-1:DATA_W]};
      REG_DATA:    io_rdata = data_q;
      default:     io_rdata = {{(DATA_W-4){1'b0}}, ie_q, armed, busy, rd_pend_q};
    endcase
  end

  // R4: a store begins only out of an armed unlock
  p_start_armed_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(armed));
  // R9: never start beside flash programming
  p_no_start_flash_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !$past(flash_busy));
  // R8: address frozen while a store runs
  p_addr_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(addr_q));
  // R10: interrupt only from its qualifying terms
  p_irq_src_r10: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ie_q && !busy && gie));
  // R7: an accepted read stalls the CPU
  p_rd_stall_r7: assert property (@(posedge clk) disable iff (rst)
    rd_go |=> cpu_stall);
endmodule

// File: tb/nvm_guard_ctrl_tb.sv
module nvm_guard_ctrl_tb;
  localparam int TICKS    = 10;
  localparam int TICK_DIV = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] io_sel = 2'd0;
  logic       io_we = 1'b0;
  logic [7:0] io_wdata = 8'h00;
  logic [7:0] io_rdata;
  logic       tick = 1'b0;
  logic       flash_busy = 1'b0;
  logic       gie = 1'b0;
  logic       cpu_stall, irq;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int tdiv = 0;
  bit done = 0;

  always #5 clk = ~clk;

  nvm_guard_ctrl #(.WRITE_TICKS(TICKS)) u_dut (
    .clk(clk), .rst(rst), .io_sel(io_sel), .io_we(io_we), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .tick(tick), .flash_busy(flash_busy), .gie(gie),
    .cpu_stall(cpu_stall), .irq(irq)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    tdiv <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
    tick <= (tdiv == TICK_DIV - 1);
  end

  // {kind, sel, wdata, expected}; kind 0 -> R1, 1 -> R2
  localparam logic [18:0] VEC [8] = '{
    {1'b0, 2'd0, 8'h5A, 8'h5A},
    {1'b0, 2'd1, 8'hFF, 8'h01},
    {1'b0, 2'd1, 8'hFE, 8'h00},
    {1'b0, 2'd2, 8'hC3, 8'hC3},
    {1'b1, 2'd3, 8'h08, 8'h08},
    {1'b1, 2'd3, 8'hF8, 8'h08},
    {1'b1, 2'd3, 8'h00, 8'h00},
    {1'b0, 2'd0, 8'h00, 8'h00}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    io_sel = s; io_wdata = d; io_we = 1'b1;
    @(negedge clk);
    io_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] v);
    io_sel = s;
    #1;
    v = io_rdata;
  endtask

  task automatic count_stall(output int n);
    n = 0;
    repeat (8) begin
      if (cpu_stall) n++;
      @(negedge clk);
    end
  endtask

  task automatic wait_idle(input int start_cyc, output int elapsed);
    logic [7:0] v;
    elapsed = -1;
    for (int i = 0; i < 500; i++) begin
      rd(2'd3, v);
      if (!v[1]) begin
        elapsed = cyc - start_cyc;
        break;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int n, el, sc;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), v);
      check("R11 reg reset", v, 0);
    end
    check("R11 stall reset", cpu_stall, 0);
    check("R11 irq reset", irq, 0);
    @(negedge clk);

    // Register map table
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][17:16], VEC[i][15:8]);
      rd(VEC[i][17:16], v);
      check(VEC[i][18] ? "R2 ctrl map" : "R1 addr map", v, VEC[i][7:0]);
      @(negedge clk);
    end

    // R4: strobe without arm, and arm+strobe in one write
    wr(2'd3, 8'h02);
    rd(2'd3, v);
    check("R4 unarmed strobe", v, 8'h00);
    check("R4 no stall", cpu_stall, 0);
    @(negedge clk);
    wr(2'd3, 8'h06);
    rd(2'd3, v);
    check("R4 combined only arms", v, 8'h04);
    repeat (6) @(negedge clk);

    // R3 arm lifetime
    wr(2'd3, 8'h04);
    repeat (3) @(negedge clk);
    rd(2'd3, v);
    check("R3 armed at 4th cycle", v[2], 1);
    @(negedge clk);
    rd(2'd3, v);
    check("R3 arm expired", v[2], 0);
    @(negedge clk);

    // R3 strobe on fifth edge refused
    wr(2'd3, 8'h04);
    repeat (4) @(negedge clk);
    wr(2'd3, 8'h02);
    rd(2'd3, v);
    check("R3 late strobe refused", v[1], 0);
    repeat (6) @(negedge clk);

    // R9 flash busy blocks
    flash_busy = 1'b1;
    wr(2'd3, 8'h04);
    wr(2'd3, 8'h02);
    rd(2'd3, v);
    check("R9 flash blocks start", v[1], 0);
    check("R9 no stall", cpu_stall, 0);
    flash_busy = 1'b0;
    repeat (6) @(negedge clk);

    // Store on fourth edge after arming
    wr(2'd0, 8'hA5);
    wr(2'd1, 8'h01);
    wr(2'd2, 8'h3C);
    wr(2'd3, 8'h04);
    repeat (3) @(negedge clk);
    wr(2'd3, 8'h06);
    sc = cyc;
    rd(2'd3, v);
    check("R3 strobe on 4th edge accepted", v[1], 1);
    count_stall(n);
    check("R7 write stall cycles", n, 2);

    // R8 lockouts while busy
    gie = 1'b1;
    wr(2'd0, 8'h00);
    rd(2'd0, v);
    check("R8 addr lo locked", v, 8'hA5);
    wr(2'd1, 8'h00);
    rd(2'd1, v);
    check("R8 addr hi locked", v, 8'h01);
    wr(2'd2, 8'h77);
    wr(2'd3, 8'h09);
    check("R8 read ignored no stall", cpu_stall, 0);
    @(negedge clk);
    rd(2'd2, v);
    check("R8 data unchanged", v, 8'h77);
    check("R10 irq low while busy", irq, 0);

    wait_idle(sc, el);
    check("R5 duration in window", (el > (TICKS - 1) * TICK_DIV) && (el <= TICKS * TICK_DIV), 1);
    @(negedge clk);
    check("R10 irq when ready", irq, 1);
    gie = 1'b0;
    @(negedge clk);
    check("R10 irq gated by gie", irq, 0);

    // R6 readback
    wr(2'd3, 8'h01);
    rd(2'd3, v);
    check("R6 read bit visible", v[0], 1);
    count_stall(n);
    check("R7 read stall cycles", n, 4);
    rd(2'd2, v);
    check("R5 stored byte", v, 8'h3C);
    rd(2'd3, v);
    check("R6 read bit self clears", v[0], 0);

    // Second store at address 0, armed then immediate strobe
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'hE1);
    wr(2'd3, 8'h04);
    wr(2'd3, 8'h02);
    sc = cyc;
    wait_idle(sc, el);
    check("R5 second store done", el > 0, 1);
    @(negedge clk);
    wr(2'd3, 8'h01);
    @(negedge clk);
    rd(2'd2, v);
    check("R6 read addr 0", v, 8'hE1);
    wr(2'd0, 8'hA5);
    wr(2'd1, 8'h01);
    wr(2'd3, 8'h01);
    @(negedge clk);
    rd(2'd2, v);
    check("R6 read addr 1A5 kept", v, 8'h3C);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule